// File: doc/BRIEF.md
# Width-Selectable Integer ALU with Narrow-Result Flags

This block performs one integer operation per execute strobe on a 32-bit datapath, at a chosen width of 8, 16 or 32 bits. The first operand always comes from a register value. The second operand is either a second register value or an immediate field that is zero-extended.

Before the operation, both operands are cut to the selected width. The result is cut to that width again and zero-extended back to 32 bits. The zero, negative, carry and overflow flags all describe the narrow result, never the full 32-bit word.

The result and the four flags sit in registers. They change only in a cycle where the execute strobe is high, so a sequencer can present operands early and commit them in its execute step.

Top module: `alu_width`

## Requirements
- R1: While `rst` is high at a rising edge, the next state of `result` is 0 and all four flags are 0.
- R2: `result` and the flags load on a rising edge only when `exec_en` is high. Otherwise they keep their value whatever the other inputs do.
- R3: When `use_imm` is 1, `imm_val` zero-extended to 32 bits replaces `src_b` as the second operand. When it is 0, `src_b` is used.
- R4: `width_sel` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Both operands are masked to that width, and `result` holds the masked result with every bit above the width at 0.
- R5: `op_sel` 0 is ADD, 1 is SUB (first minus second), 2 is AND, 3 is OR and 4 is XOR. Codes 5 to 7 give a result of 0.
- R6: `flag_z` is 1 exactly when the masked result is 0.
- R7: `flag_n` equals the most significant bit of the selected width in the masked result.
- R8: `flag_c` is the carry out of the selected width for ADD. For SUB it is the borrow: 1 when the masked first operand is below the masked second operand. It is 0 for every other code.
- R9: `flag_v` is the signed overflow at the selected width for ADD and SUB, and is 0 for every other code.
- R10: A byte SUB of immediate 0x01 from 0x00000001 gives a result of 0x00000000 with `flag_z` at 1 and the other three flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; loads result and flags |
| op_sel | input | 3 | Operation code |
| width_sel | input | 2 | Operation width code |
| use_imm | input | 1 | Take the immediate as the second operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm_val | input | 16 | Immediate operand, zero-extended |
| result | output | 32 | Registered masked, zero-extended result |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry / borrow flag |
| flag_v | output | 1 | Registered signed overflow flag |

## Verification
The assertions assume that every control input (`exec_en`, `op_sel`, `width_sel` and `use_imm`) is a known 0 or 1 at each rising edge after reset, because the width and operation checks are gated on those values. They also assume that reset is held for at least one edge before the first execute.

The stimulus changes inputs only at falling edges and holds reset for several cycles. It drives all eight operation codes and all four width codes, including the spare ones, so every value the properties decode appears with defined inputs.

// File: rtl/alu_width_pkg.sv
package alu_width_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    WID_BYTE  = 2'd0,
    WID_HALF  = 2'd1,
    WID_WORD  = 2'd2,
    WID_WORD2 = 2'd3
  } alu_width_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu_width_decode.sv
// Turns the width code into a lane mask, a one-hot for the top bit of
// the lane and a one-hot for the carry position just above it.
module alu_width_decode #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] msb_hot,
  output logic [DATA_W:0]   carry_hot
);
  import alu_width_pkg::*;

  logic sel_byte;
  logic sel_half;
  logic [DATA_W:0] mask_ext;

  assign sel_byte = (width_sel == WID_BYTE);
  assign sel_half = (width_sel == WID_HALF);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < BYTE_W) begin : g_byte
      assign lane_mask[i] = 1'b1;
    end else if (i < HALF_W) begin : g_half
      assign lane_mask[i] = !sel_byte;
    end else begin : g_word
      assign lane_mask[i] = !sel_byte && !sel_half;
    end
  end

  assign mask_ext = {1'b0, lane_mask};

  for (genvar i = 0; i < DATA_W; i++) begin : g_msb
    assign msb_hot[i] = mask_ext[i] && !mask_ext[i+1];
  end

  assign carry_hot[0] = 1'b0;
  for (genvar i = 1; i <= DATA_W; i++) begin : g_cy
    assign carry_hot[i] = mask_ext[i-1] && !mask_ext[i];
  end

endmodule

// File: rtl/alu_operand_stage.sv
// Picks the second operand and trims both operands to the lane.
module alu_operand_stage #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_pick;

  assign imm_ext = {{PAD_W{1'b0}}, imm_val};
  assign b_pick  = use_imm ? imm_ext : src_b;
  assign opa     = src_a  & lane_mask;
  assign opb     = b_pick & lane_mask;

endmodule

// File: rtl/alu_compute.sv
// Full-width arithmetic and logic on pre-masked operands, one bit wider
// so that the carry or borrow of the top lane bit is kept.
module alu_compute #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W:0]   raw,
  output logic              is_add,
  output logic              is_sub
);
  import alu_width_pkg::*;

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] diff_w;

  assign sum_w  = {1'b0, opa} + {1'b0, opb};
  assign diff_w = {1'b0, opa} - {1'b0, opb};

  always_comb begin
    is_add = 1'b0;
    is_sub = 1'b0;
    raw    = '0;
    case (op_sel)
      OP_ADD: begin raw = sum_w;  is_add = 1'b1; end
      OP_SUB: begin raw = diff_w; is_sub = 1'b1; end
      OP_AND: raw = {1'b0, opa & opb};
      OP_OR:  raw = {1'b0, opa | opb};
      OP_XOR: raw = {1'b0, opa ^ opb};
      default: raw = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
// Masks the raw result to the lane and derives flags from the lane only.
module alu_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W:0]   raw,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] msb_hot,
  input  logic [DATA_W:0]   carry_hot,
  input  logic              is_add,
  input  logic              is_sub,
  output logic [DATA_W-1:0] res,
  output alu_width_pkg::alu_flags_t flags
);
  logic a_top;
  logic b_top;
  logic r_top;
  logic cy_bit;

  assign res    = raw[DATA_W-1:0] & lane_mask;
  assign a_top  = |(opa & msb_hot);
  assign b_top  = |(opb & msb_hot);
  assign r_top  = |(res & msb_hot);
  assign cy_bit = |(raw & carry_hot);

  always_comb begin
    flags.z = (res == '0);
    flags.n = r_top;
    flags.c = (is_add || is_sub) && cy_bit;
    if (is_add)
      flags.v = (a_top == b_top) && (r_top != a_top);
    else if (is_sub)
      flags.v = (a_top != b_top) && (r_top != a_top);
    else
      flags.v = 1'b0;
  end

endmodule

// File: rtl/alu_width.sv
module alu_width #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        width_sel,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_c,
  output logic              flag_v
);
  import alu_width_pkg::*;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] msb_hot;
  logic [DATA_W:0]   carry_hot;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W:0]   raw;
  logic              is_add;
  logic              is_sub;
  logic [DATA_W-1:0] res_d;
  alu_flags_t        flags_d;
  alu_flags_t        flags_q;

  alu_width_decode #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_dec (
    .width_sel (width_sel),
    .lane_mask (lane_mask),
    .msb_hot   (msb_hot),
    .carry_hot (carry_hot)
  );

  alu_operand_stage #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .src_a     (src_a),
    .src_b     (src_b),
    .imm_val   (imm_val),
    .use_imm   (use_imm),
    .lane_mask (lane_mask),
    .opa       (opa),
    .opb       (opb)
  );

  alu_compute #(.DATA_W(DATA_W)) u_cmp (
    .op_sel (op_sel),
    .opa    (opa),
    .opb    (opb),
    .raw    (raw),
    .is_add (is_add),
    .is_sub (is_sub)
  );

  alu_flag_gen #(.DATA_W(DATA_W)) u_flg (
    .raw       (raw),
    .opa       (opa),
    .opb       (opb),
    .lane_mask (lane_mask),
    .msb_hot   (msb_hot),
    .carry_hot (carry_hot),
    .is_add    (is_add),
    .is_sub    (is_sub),
    .res       (res_d),
    .flags     (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      flags_q <= '0;
    end else if (exec_en) begin
      result  <= res_d;
      flags_q <= flags_d;
    end
  end

  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/alu_width_checker.sv
module alu_width_checker #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_en,
  input logic [2:0]        op_sel,
  input logic [1:0]        width_sel,
  input logic [DATA_W-1:0] result,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_c,
  input logic              flag_v
);

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0) && !flag_z && !flag_n && !flag_c && !flag_v);

  // R2
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(result) && $stable({flag_z, flag_n, flag_c, flag_v}));

  // R4
  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && width_sel == 2'd0) |=> (result[DATA_W-1:BYTE_W] == '0));

  // R4
  assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && width_sel == 2'd1) |=> (result[DATA_W-1:HALF_W] == '0));

  // R5
  assert_spare_op_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel > 3'd4) |=> (result == '0) && flag_z);

  // R7
  assert_byte_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && width_sel == 2'd0) |=> (flag_n == result[BYTE_W-1]));

  // R8
  assert_no_carry_logic_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel > 3'd1) |=> !flag_c);

  // R9
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel > 3'd1) |=> !flag_v);

endmodule

bind alu_width alu_width_checker #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exec_en   (exec_en),
  .op_sel    (op_sel),
  .width_sel (width_sel),
  .result    (result),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .flag_c    (flag_c),
  .flag_v    (flag_v)
);

// File: tb/alu_width_bench.sv
module alu_width_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  width_sel = '0;
  logic        use_imm = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm_val = '0;
  logic [31:0] result;
  logic        flag_z, flag_n, flag_c, flag_v;

  int checks = 0;
  int failures = 0;
  logic [35:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_width u_alu_width (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
    .width_sel(width_sel), .use_imm(use_imm), .src_a(src_a), .src_b(src_b),
    .imm_val(imm_val), .result(result), .flag_z(flag_z), .flag_n(flag_n),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  // Reference model, written from the requirements: {result, z, n, c, v}
  function automatic logic [35:0] model(input logic [2:0] op, input logic [1:0] wid,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] imm, input logic ui);
    int w;
    logic [63:0] m, am, bm, full, r;
    logic c, v, z, n;
    w = (wid == 2'd0) ? 8 : (wid == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    am = {32'd0, a} & m;
    bm = (ui ? {48'd0, imm} : {32'd0, b}) & m;
    c = 1'b0; v = 1'b0;
    case (op)
      3'd0: begin
        full = am + bm; r = full & m; c = full[w];
        v = (am[w-1] == bm[w-1]) && (r[w-1] != am[w-1]);
      end
      3'd1: begin
        r = (am - bm) & m; c = (am < bm);
        v = (am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]);
      end
      3'd2: r = am & bm;
      3'd3: r = am | bm;
      3'd4: r = am ^ bm;
      default: r = 64'd0;
    endcase
    z = (r == 64'd0);
    n = r[w-1];
    return {r[31:0], z, n, c, v};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual res=%h zncv=%b expected res=%h zncv=%b",
               tag, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  // Driver: one execute per call, expected item queued at the same time
  task automatic drive(input string tag, input logic [2:0] op, input logic [1:0] wid,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic ui);
    @(negedge clk);
    op_sel = op; width_sel = wid; src_a = a; src_b = b; imm_val = imm; use_imm = ui;
    exec_en = 1'b1;
    expq.push_back(model(op, wid, a, b, imm, ui));
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  // Monitor: after each edge that captured, compare against the queue head
  initial begin
    forever begin
      logic pend;
      @(posedge clk);
      pend = exec_en && !rst;
      #2;
      if (pend) begin
        if (expq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 actual unexpected capture expected none");
        end else begin
          check(tagq.pop_front(), {result, flag_z, flag_n, flag_c, flag_v}, expq.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] held;
    repeat (4) @(negedge clk);
    check("R1 reset", {result, flag_z, flag_n, flag_c, flag_v}, 36'd0);
    rst = 1'b0;

    // R10 byte sub of immediate 1 from 1
    drive("R10 byte sub", 3'd1, 2'd0, 32'h1, 32'hFFFF_FFFF, 16'h0001, 1'b1);
    idle();
    check("R10 direct", {result, flag_z, flag_n, flag_c, flag_v}, {32'h0, 4'b1000});

    // R3 immediate versus register
    drive("R3 imm", 3'd0, 2'd2, 32'h1000_0000, 32'h0000_0005, 16'hFFFF, 1'b1);
    drive("R3 reg", 3'd0, 2'd2, 32'h1000_0000, 32'h0000_0005, 16'hFFFF, 1'b0);
    // R4 masking of upper operand bits, all four codes
    drive("R4 byte", 3'd0, 2'd0, 32'hABCD_12F0, 32'h5555_0020, 16'h0, 1'b0);
    drive("R4 half", 3'd0, 2'd1, 32'hABCD_F000, 32'h5555_2000, 16'h0, 1'b0);
    drive("R4 word", 3'd3, 2'd2, 32'hF000_0000, 32'h0000_000F, 16'h0, 1'b0);
    drive("R4 word alt", 3'd3, 2'd3, 32'hF000_0000, 32'h0000_000F, 16'h0, 1'b0);
    // R5 every opcode including spares
    for (int k = 0; k < 8; k++)
      drive("R5 op", 3'(k), 2'd1, 32'h0000_F0F0, 32'h0000_3C3C, 16'h0, 1'b0);
    // R8 carry and borrow at each width
    drive("R8 byte carry", 3'd0, 2'd0, 32'hFF, 32'h01, 16'h0, 1'b0);
    drive("R8 half borrow", 3'd1, 2'd1, 32'h0, 32'h1, 16'h0, 1'b0);
    drive("R8 word carry", 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h2, 16'h0, 1'b0);
    drive("R8 word borrow", 3'd1, 2'd3, 32'h5, 32'h6, 16'h0, 1'b0);
    // R9 signed overflow at each width, R7 negative
    drive("R9 byte add ovf", 3'd0, 2'd0, 32'h7F, 32'h01, 16'h0, 1'b0);
    drive("R9 half sub ovf", 3'd1, 2'd1, 32'h8000, 32'h0001, 16'h0, 1'b0);
    drive("R9 word add ovf", 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0);
    drive("R7 byte neg", 3'd4, 2'd0, 32'h0, 32'h80, 16'h0, 1'b0);
    // R6 zero from narrow result while full value nonzero
    drive("R6 half zero", 3'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 16'h0, 1'b0);
    idle();

    // R2 hold while exec_en low and inputs change
    @(negedge clk);
    held = {result, flag_z, flag_n, flag_c, flag_v};
    op_sel = 3'd0; width_sel = 2'd2; src_a = 32'h1234_5678; src_b = 32'h1111_1111;
    repeat (3) @(negedge clk);
    check("R2 hold", {result, flag_z, flag_n, flag_c, flag_v}, held);

    // Broad mix of operands, widths and ops
    for (int k = 0; k < 300; k++) begin
      drive("R4 R5 R8 R9 mix", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
            $urandom(), $urandom(), 16'($urandom()), 1'($urandom_range(0, 1)));
      if (k % 7 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);

    // R1 reset mid-run clears state
    drive("R1 pre", 3'd3, 2'd2, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0);
    idle();
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {result, flag_z, flag_n, flag_c, flag_v}, 36'd0);
    rst = 1'b0;
    @(negedge clk);

    if (expq.size() != 0) begin
      checks++; failures++;
      $display("FAIL R2 actual %0d pending expected 0", expq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule